// File: doc/BRIEF.md
# Cursor Register Arming Bank

This block holds the programming registers of a hardware cursor plane between a CPU write port and the display scanout. There are four registers: control, position, base address and height override. Every register has two copies. CPU writes land in the pending copy, and scanout reads only the active copy. Pending values move to the active copy on a one-cycle vertical-blank strobe, and only after an arming event has occurred since the last transfer.

Arming is tied to the order of the writes rather than to individual registers:

- Writing the base register arms a full transfer.
- Enabling a cursor that is currently off arms through the control write.
- Any other write while an update is armed cancels that update, so software ends each update with a base write.

A position-arming mode lets a position write alone arm a position-only move. A legacy mode instead refuses base and size changes while the cursor is enabled, and arms on every accepted write.

The position register is sign-magnitude. The block decodes it into two's-complement X and Y outputs for the scanout. Reads return pending values, and the `armed` output shows whether a transfer is waiting.

Top module: `cursor_arm_bank`

## Requirements
- R1: After synchronous reset:
  - all pending and active registers are zero;
  - `armed` is 0;
  - the cursor is disabled (`act_enable` is 0).
- R2: Register addresses and reads:
  - The addresses are 0 control (bit 0 is the enable), 1 position, 2 base, 3 height override.
  - A read with `rd_en` returns the pending (last accepted) value of the addressed register on `rd_data` one cycle later.
- R3: Active registers change only in the cycle after a `vblank` strobe that finds `armed` set. That same strobe clears `armed`.
- R4: In modes 0 and 1, a base write arms a full transfer. A full transfer copies all four pending registers to active.
- R5: In modes 0 and 1, a control write arms a full transfer, with no base write needed, when its bit 0 is 1 and the active enable is 0.
- R6: In modes 0 and 1, the following writes clear `armed`, after which a strobe transfers nothing:
  - a height-override write;
  - a control write that does not arm under R5;
  - a position write that does not arm under R7.
  A later base write arms again.
- R7: In mode 1, a position write arms a position-only transfer if no control write has occurred since the last arming event. A position-only transfer copies the position register alone.
- R8: Position layout: X magnitude in bits [POS_W-1:0], X sign in bit 15, Y magnitude in bits [16+POS_W-1:16], Y sign in bit 31. `act_x` and `act_y` give the two's-complement values, and a negative zero reads as 0.
- R9: In mode 2 (legacy):
  - base and height-override writes are dropped while the pending control enable is 1;
  - every accepted write arms a full transfer.
- R10: Height override: bit 31 is the enable and bits [HGT_W-1:0] hold height minus one. They appear on `act_hovr_en` and `act_height_m1`.
- R11: Mode value 3 behaves exactly as mode 0.
- R12: When a write coincides with a `vblank` strobe:
  - the transfer uses the pending values from before the write;
  - `armed` afterwards follows that write's own effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 0 standard, 1 position arming, 2 legacy, 3 as standard |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read register address |
| rd_data | output | DATA_W | Pending value of the read register, one cycle after the read |
| vblank | input | 1 | One-cycle frame boundary strobe |
| armed | output | 1 | A transfer is waiting for the next strobe |
| act_enable | output | 1 | Active cursor enable |
| act_ctrl | output | DATA_W | Active control word |
| act_base | output | DATA_W | Active base address |
| act_pos | output | DATA_W | Active raw position word |
| act_x | output | POS_W+1 | Active X, two's complement |
| act_y | output | POS_W+1 | Active Y, two's complement |
| act_hovr | output | DATA_W | Active raw height-override word |
| act_hovr_en | output | 1 | Active height-override enable |
| act_height_m1 | output | HGT_W | Active height minus one |

## Verification
The assertions assume the following about the inputs:
- `vblank` is a strobe;
- `mode_sel` holds steady between the writes it governs;
- reads and writes are single-cycle requests that need no handshake.

The bench drives every input at the falling edge for exactly one cycle. It changes the mode only while the bank is idle, and it raises `vblank` together with a write only in the one directed case that checks that collision.

// File: rtl/cursor_arm_pkg.sv
package cursor_arm_pkg;
  localparam int NREG = 4;
  localparam int CTRL_EN_BIT = 0;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_POS  = 2'd1,
    REG_BASE = 2'd2,
    REG_HOVR = 2'd3
  } cur_reg_e;

  typedef enum logic [1:0] {
    MODE_STD    = 2'd0,
    MODE_POSARM = 2'd1,
    MODE_LEGACY = 2'd2,
    MODE_RSVD   = 2'd3
  } cur_mode_e;
endpackage

// File: rtl/cursor_arm_ctrl.sv
module cursor_arm_ctrl
  import cursor_arm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic       wr_en_bit,
  input  logic       act_en,
  input  logic       pend_en,
  input  logic       vblank,
  output logic       accept,
  output logic       armed,
  output logic       arm_full,
  output logic       xfer_full,
  output logic       xfer_pos
);
  logic legacy, posarm;
  logic armed_n, full_n;
  logic ctrl_since_q, ctrl_since_n;

  assign legacy = (mode_sel == MODE_LEGACY);
  assign posarm = (mode_sel == MODE_POSARM);

  // legacy mode refuses base and size changes while the cursor is enabled
  assign accept = wr_en && !(legacy && pend_en &&
                  (wr_addr == REG_BASE || wr_addr == REG_HOVR));

  assign xfer_full = vblank && armed && arm_full;
  assign xfer_pos  = vblank && armed && !arm_full;

  always_comb begin
    armed_n      = vblank ? 1'b0 : armed;
    full_n       = arm_full;
    ctrl_since_n = ctrl_since_q;
    if (accept) begin
      if (legacy) begin
        armed_n = 1'b1;
        full_n  = 1'b1;
      end else begin
        unique case (wr_addr)
          REG_BASE: begin
            armed_n      = 1'b1;
            full_n       = 1'b1;
            ctrl_since_n = 1'b0;
          end
          REG_CTRL: begin
            if (wr_en_bit && !act_en) begin
              armed_n      = 1'b1;
              full_n       = 1'b1;
              ctrl_since_n = 1'b0;
            end else begin
              armed_n      = 1'b0;
              ctrl_since_n = 1'b1;
            end
          end
          REG_POS: begin
            if (posarm && !ctrl_since_q) begin
              armed_n = 1'b1;
              full_n  = 1'b0;
            end else begin
              armed_n = 1'b0;
            end
          end
          default: armed_n = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed        <= 1'b0;
      arm_full     <= 1'b1;
      ctrl_since_q <= 1'b0;
    end else begin
      armed        <= armed_n;
      arm_full     <= full_n;
      ctrl_since_q <= ctrl_since_n;
    end
  end

  p_vblank_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (vblank && !wr_en) |=> !armed);
  p_base_arms_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_BASE && mode_sel != MODE_LEGACY) |=> (armed && arm_full));
  p_hovr_cancels_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_HOVR && mode_sel != MODE_LEGACY) |=> !armed);
  p_legacy_arms_r9: assert property (@(posedge clk) disable iff (rst)
    (accept && legacy) |=> (armed && arm_full));
endmodule

// File: rtl/cursor_reg_stage.sv
module cursor_reg_stage
  import cursor_arm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NR     = NREG,
  localparam int AW    = $clog2(NR)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_acc,
  input  logic [AW-1:0]              wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       xfer_full,
  input  logic                       xfer_pos,
  input  logic                       rd_en,
  input  logic [AW-1:0]              rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NR-1:0][DATA_W-1:0]  pend_o,
  output logic [NR-1:0][DATA_W-1:0]  act_o
);
  for (genvar g = 0; g < NR; g++) begin : g_reg
    localparam logic IS_POS = (g == int'(REG_POS));
    always_ff @(posedge clk) begin
      if (rst) pend_o[g] <= '0;
      else if (wr_acc && wr_addr == AW'(g)) pend_o[g] <= wr_data;
    end
    always_ff @(posedge clk) begin
      if (rst) act_o[g] <= '0;
      else if (xfer_full || (xfer_pos && IS_POS)) act_o[g] <= pend_o[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= pend_o[rd_addr];
  end
endmodule

// File: rtl/cursor_pos_decode.sv
module cursor_pos_decode #(
  parameter int DATA_W = 32,
  parameter int POS_W  = 12,
  localparam int HALF  = DATA_W / 2
) (
  input  logic [DATA_W-1:0]      pos_word,
  output logic signed [POS_W:0]  x,
  output logic signed [POS_W:0]  y
);
  logic signed [POS_W:0] xm, ym;
  assign xm = $signed({1'b0, pos_word[POS_W-1:0]});
  assign ym = $signed({1'b0, pos_word[HALF+POS_W-1:HALF]});
  assign x  = pos_word[HALF-1]   ? -xm : xm;
  assign y  = pos_word[DATA_W-1] ? -ym : ym;
endmodule

// File: rtl/cursor_arm_bank.sv
module cursor_arm_bank
  import cursor_arm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = 12,
  parameter int HGT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               mode_sel,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_en,
  input  logic [1:0]               rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     vblank,
  output logic                     armed,
  output logic                     act_enable,
  output logic [DATA_W-1:0]        act_ctrl,
  output logic [DATA_W-1:0]        act_base,
  output logic [DATA_W-1:0]        act_pos,
  output logic signed [POS_W:0]    act_x,
  output logic signed [POS_W:0]    act_y,
  output logic [DATA_W-1:0]        act_hovr,
  output logic                     act_hovr_en,
  output logic [HGT_W-1:0]         act_height_m1
);
  localparam int HOVR_EN_BIT = DATA_W - 1;

  logic accept, arm_full, xfer_full, xfer_pos;
  logic [NREG-1:0][DATA_W-1:0] pend, act;

  cursor_arm_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_en_bit (wr_data[CTRL_EN_BIT]),
    .act_en    (act[REG_CTRL][CTRL_EN_BIT]),
    .pend_en   (pend[REG_CTRL][CTRL_EN_BIT]),
    .vblank    (vblank),
    .accept    (accept),
    .armed     (armed),
    .arm_full  (arm_full),
    .xfer_full (xfer_full),
    .xfer_pos  (xfer_pos)
  );

  cursor_reg_stage #(.DATA_W(DATA_W), .NR(NREG)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_acc    (accept),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .xfer_full (xfer_full),
    .xfer_pos  (xfer_pos),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .pend_o    (pend),
    .act_o     (act)
  );

  cursor_pos_decode #(.DATA_W(DATA_W), .POS_W(POS_W)) u_pos (
    .pos_word (act[REG_POS]),
    .x        (act_x),
    .y        (act_y)
  );

  assign act_ctrl      = act[REG_CTRL];
  assign act_enable    = act[REG_CTRL][CTRL_EN_BIT];
  assign act_base      = act[REG_BASE];
  assign act_pos       = act[REG_POS];
  assign act_hovr      = act[REG_HOVR];
  assign act_hovr_en   = act[REG_HOVR][HOVR_EN_BIT];
  assign act_height_m1 = act[REG_HOVR][HGT_W-1:0];

  p_active_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(vblank && armed) |=> ($stable(act_base) && $stable(act_pos) &&
                             $stable(act_ctrl) && $stable(act_hovr)));
  p_pos_only_keeps_base_r7: assert property (@(posedge clk) disable iff (rst)
    (vblank && armed && !arm_full) |=> ($stable(act_base) && $stable(act_ctrl)));
  p_legacy_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode_sel == MODE_LEGACY && pend[REG_CTRL][CTRL_EN_BIT] &&
     wr_addr == REG_BASE) |=> $stable(pend[REG_BASE]));
  p_full_copy_r4: assert property (@(posedge clk) disable iff (rst)
    (vblank && armed && arm_full) |=> (act_base == $past(pend[REG_BASE])));
endmodule

// File: tb/tb_cursor_arm_bank.sv
`timescale 1ns/1ps
module tb_cursor_arm_bank;
  localparam int DW = 32;
  localparam int PW = 12;
  localparam int HW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode_sel = 2'd0;
  logic wr_en = 1'b0, rd_en = 1'b0, vblank = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data, act_ctrl, act_base, act_pos, act_hovr;
  logic armed, act_enable, act_hovr_en;
  logic signed [PW:0] act_x, act_y;
  logic [HW-1:0] act_height_m1;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cursor_arm_bank #(.DATA_W(DW), .POS_W(PW), .HGT_W(HW)) dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .vblank(vblank), .armed(armed), .act_enable(act_enable), .act_ctrl(act_ctrl),
    .act_base(act_base), .act_pos(act_pos), .act_x(act_x), .act_y(act_y),
    .act_hovr(act_hovr), .act_hovr_en(act_hovr_en), .act_height_m1(act_height_m1)
  );

  // {vblank, wr_en, addr, data, expected armed, expected act_base}, mode 0
  localparam int NV = 8;
  localparam logic [68:0] VEC [0:NV-1] = '{
    {1'b0, 1'b1, 2'd2, 32'h0000_1000, 1'b1, 32'h0000_0000},
    {1'b1, 1'b0, 2'd0, 32'h0000_0000, 1'b0, 32'h0000_1000},
    {1'b0, 1'b1, 2'd1, 32'h8005_0003, 1'b0, 32'h0000_1000},
    {1'b0, 1'b1, 2'd2, 32'h0000_2000, 1'b1, 32'h0000_1000},
    {1'b0, 1'b1, 2'd3, 32'h8000_0007, 1'b0, 32'h0000_1000},
    {1'b1, 1'b0, 2'd0, 32'h0000_0000, 1'b0, 32'h0000_1000},
    {1'b0, 1'b1, 2'd2, 32'h0000_3000, 1'b1, 32'h0000_1000},
    {1'b1, 1'b0, 2'd0, 32'h0000_0000, 1'b0, 32'h0000_3000}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic step(input logic vb, input logic we, input logic [1:0] a, input logic [DW-1:0] d);
    vblank = vb; wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    vblank = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 armed", 64'(armed), 64'd0);
    chk("R1 enable", 64'(act_enable), 64'd0);
    chk("R1 base", 64'(act_base), 64'd0);
    chk("R1 hovr", 64'(act_hovr), 64'd0);
    rd(2'd2);
    chk("R1 pending base", 64'(rd_data), 64'd0);

    // R4 R6 R3 vector walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][68], VEC[i][67], VEC[i][66:65], VEC[i][64:33]);
      chk("R4/R6 armed", 64'(armed), 64'(VEC[i][32]));
      chk("R3 act_base", 64'(act_base), 64'(VEC[i][31:0]));
    end
    // R8 sign-magnitude decode of 0x8005_0003
    chk("R8 x", 64'(act_x), 64'sd3);
    chk("R8 y", 64'(act_y), -64'sd5);

    // R5 enabling control write arms alone
    step(1'b0, 1'b1, 2'd0, 32'h0000_0001);
    chk("R5 armed", 64'(armed), 64'd1);
    step(1'b1, 1'b0, 2'd0, '0);
    chk("R5 enable", 64'(act_enable), 64'd1);
    chk("R10 hovr en", 64'(act_hovr_en), 64'd1);
    chk("R10 height", 64'(act_height_m1), 64'd7);

    // R6 control write while enabled cancels an armed base
    step(1'b0, 1'b1, 2'd2, 32'h0000_4000);
    step(1'b0, 1'b1, 2'd0, 32'h0000_0003);
    chk("R6 ctrl cancel", 64'(armed), 64'd0);
    step(1'b1, 1'b0, 2'd0, '0);
    chk("R6 base held", 64'(act_base), 64'h3000);
    chk("R6 ctrl held", 64'(act_ctrl), 64'h1);

    // R7 position arming mode
    mode_sel = 2'd1;
    step(1'b0, 1'b1, 2'd1, 32'h0000_8002);
    chk("R7 blocked after ctrl", 64'(armed), 64'd0);
    step(1'b0, 1'b1, 2'd2, 32'h0000_4000);
    step(1'b1, 1'b0, 2'd0, '0);
    chk("R7 full base", 64'(act_base), 64'h4000);
    chk("R8 neg x", 64'(act_x), -64'sd2);
    step(1'b0, 1'b1, 2'd3, 32'h0000_0010);
    step(1'b0, 1'b1, 2'd1, 32'h0007_8000);
    chk("R7 pos arms", 64'(armed), 64'd1);
    step(1'b1, 1'b0, 2'd0, '0);
    chk("R7 y moved", 64'(act_y), 64'sd7);
    chk("R8 negative zero", 64'(act_x), 64'd0);
    chk("R7 hovr untouched", 64'(act_hovr_en), 64'd1);

    // R11 mode 3 acts as mode 0
    mode_sel = 2'd3;
    step(1'b0, 1'b1, 2'd2, 32'h0000_5000);
    step(1'b0, 1'b1, 2'd1, 32'h0000_0001);
    chk("R11 pos cancels", 64'(armed), 64'd0);
    step(1'b0, 1'b1, 2'd2, 32'h0000_5000);

    // R12 write with strobe in same cycle
    step(1'b1, 1'b1, 2'd3, 32'h8000_0020);
    chk("R12 armed", 64'(armed), 64'd0);
    chk("R12 base", 64'(act_base), 64'h5000);
    chk("R12 old hovr", 64'(act_hovr), 64'h10);
    step(1'b1, 1'b0, 2'd0, '0);
    chk("R12 no second copy", 64'(act_hovr), 64'h10);

    // R9 legacy mode
    mode_sel = 2'd2;
    step(1'b0, 1'b1, 2'd2, 32'h0000_6000);
    chk("R9 drop not armed", 64'(armed), 64'd0);
    rd(2'd2);
    chk("R9 drop base", 64'(rd_data), 64'h5000);
    step(1'b0, 1'b1, 2'd0, 32'h0000_0000);
    chk("R9 ctrl arms", 64'(armed), 64'd1);
    step(1'b0, 1'b1, 2'd2, 32'h0000_6000);
    rd(2'd2);
    chk("R2 read base", 64'(rd_data), 64'h6000);
    step(1'b1, 1'b0, 2'd0, '0);
    chk("R9 disabled", 64'(act_enable), 64'd0);
    chk("R9 base", 64'(act_base), 64'h6000);
    rd(2'd1);
    chk("R2 read pos", 64'(rd_data), 64'h0000_0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule